// File: doc/BRIEF.md
# Derandomizer Occupancy Emulating Trigger Gate

This block is the central gate for first-level trigger accepts. On every bunch-crossing clock it may receive an accept request. It holds a model of how full the front-end derandomizer buffers are, and it passes a request on only when that model shows room. The model is built from fixed rules: every front-end derandomizer holds at least 16 events, and each one reads out an event as 36 words (32 data plus 4 tags) at one word per clock. The model assumes one slot less than the guaranteed depth. That margin absorbs differences between front-end implementations.

An accepted event occupies the model for exactly one readout period of 36 cycles. Events drain one after another with no idle cycle between them. A throttle input from the next trigger level can also block accepts. Every request that is not passed, because the model is full or the throttle is active, increments a saturating reject counter. Requests in consecutive crossings pass with no enforced gap, up to the modelled depth.

Top module: `occ_gate`

## Requirements
- R1: While rst_ni is low, occupancy_o is 0, reject_cnt_o is 0, not_full_o is 1 and trig_acc_o is 0, whatever the inputs are.
- R2: trig_acc_o is high in a cycle exactly when trig_req_i is high, throttle_i is low and occupancy_o is below DEPTH (default 15). An accept raises occupancy_o by one at the next clock edge, unless a readout completes in the same cycle.
- R3: While throttle_i is high, trig_acc_o stays low.
- R4: Requests in up to DEPTH consecutive cycles into an empty model are all accepted. A request made while occupancy_o equals DEPTH is not accepted.
- R5: A single event accepted into an empty model keeps occupancy_o at 1 for exactly WORDS (default 36) cycles, counted from the cycle after the accept, and then returns to 0.
- R6: With several events held, occupancy_o decreases by one every WORDS cycles, with no idle cycle between readouts.
- R7: When an accept and a readout completion fall in the same cycle, occupancy_o keeps its value across that clock edge.
- R8: Every request that is not accepted raises reject_cnt_o by one at the next clock edge. The counter saturates at 2^CNT_W-1 (default 65535).
- R9: not_full_o is high exactly when occupancy_o is below DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bunch-crossing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_req_i | input | 1 | Accept request from the first-level trigger |
| throttle_i | input | 1 | Blocks accepts while high |
| trig_acc_o | output | 1 | Accept passed on to the front-ends |
| not_full_o | output | 1 | Model has at least one free slot |
| occupancy_o | output | $clog2(DEPTH+1) | Number of events held in the model |
| reject_cnt_o | output | CNT_W | Saturating count of requests that were not accepted |

## Verification
Several properties are checked on every cycle: the occupancy never exceeds the modelled depth, no accept is issued while throttled, full, or without a request, the occupancy moves by at most one per edge, an accept never lets it fall, and every rejected request advances the counter. The exact readout timing can only be shown by the bench's scenarios. These cover the 36-cycle hold of a lone event, drains spaced 36 cycles apart with no gap, the unchanged level when an accept meets a completion, the depth-limited burst and counter saturation. A reference model in the bench follows the random mix.

// File: rtl/occ_gate_pkg.sv
package occ_gate_pkg;
  localparam int unsigned DEF_DEPTH = 15;  // one below the guaranteed front-end depth
  localparam int unsigned DEF_WORDS = 36;  // 32 data + 4 tag words per event
  localparam int unsigned DEF_CNT_W = 16;

  typedef enum logic [1:0] {
    DEC_IDLE,
    DEC_ACCEPT,
    DEC_REJ_FULL,
    DEC_REJ_THROTTLE
  } decision_e;
endpackage

// File: rtl/occ_readout_timer.sv
module occ_readout_timer #(
  parameter int unsigned WORDS = occ_gate_pkg::DEF_WORDS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  output logic done_o
);
  localparam int unsigned TMR_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [TMR_W-1:0] LAST = TMR_W'(WORDS - 1);

  logic [TMR_W-1:0] tmr_q;

  assign done_o = busy_i && (tmr_q == LAST);

  // restarts at zero on idle or completion, so back-to-back events chain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tmr_q <= '0;
    else if (!busy_i || done_o) tmr_q <= '0;
    else                        tmr_q <= tmr_q + TMR_W'(1);
  end
endmodule

// File: rtl/occ_level.sv
module occ_level #(
  parameter int unsigned DEPTH = occ_gate_pkg::DEF_DEPTH,
  parameter int unsigned OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [OCC_W-1:0] occ_o,
  output logic             not_full_o,
  output logic             busy_o
);
  logic [OCC_W-1:0] occ_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= '0;
    else if (inc_i && !dec_i) occ_q <= occ_q + OCC_W'(1);
    else if (dec_i && !inc_i) occ_q <= occ_q - OCC_W'(1);
  end

  assign occ_o      = occ_q;
  assign not_full_o = occ_q < OCC_W'(DEPTH);
  assign busy_o     = occ_q != '0;
endmodule

// File: rtl/occ_reject_cnt.sv
module occ_reject_cnt #(
  parameter int unsigned CNT_W = occ_gate_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (inc_i && cnt_q != '1)   cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/occ_gate.sv
module occ_gate
  import occ_gate_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned WORDS = DEF_WORDS,
  parameter int unsigned CNT_W = DEF_CNT_W,
  localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_req_i,
  input  logic             throttle_i,
  output logic             trig_acc_o,
  output logic             not_full_o,
  output logic [OCC_W-1:0] occupancy_o,
  output logic [CNT_W-1:0] reject_cnt_o
);
  decision_e dec;
  logic      room, busy, done;

  always_comb begin
    dec = DEC_IDLE;
    if (rst_ni && trig_req_i) begin
      if (throttle_i) dec = DEC_REJ_THROTTLE;
      else if (!room) dec = DEC_REJ_FULL;
      else            dec = DEC_ACCEPT;
    end
  end

  assign trig_acc_o = (dec == DEC_ACCEPT);
  assign not_full_o = room;

  occ_level #(.DEPTH(DEPTH), .OCC_W(OCC_W)) i_level (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (trig_acc_o),
    .dec_i     (done),
    .occ_o     (occupancy_o),
    .not_full_o(room),
    .busy_o    (busy)
  );

  occ_readout_timer #(.WORDS(WORDS)) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .busy_i(busy),
    .done_o(done)
  );

  occ_reject_cnt #(.CNT_W(CNT_W)) i_rej (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (dec == DEC_REJ_FULL || dec == DEC_REJ_THROTTLE),
    .cnt_o (reject_cnt_o)
  );
endmodule

// File: rtl/occ_gate_chk.sv
module occ_gate_chk #(
  parameter int unsigned DEPTH = 15,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned OCC_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             trig_req_i,
  input logic             throttle_i,
  input logic             trig_acc_o,
  input logic             not_full_o,
  input logic [OCC_W-1:0] occupancy_o,
  input logic [CNT_W-1:0] reject_cnt_o
);
  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occupancy_o <= OCC_W'(DEPTH));

  p_acc_needs_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_acc_o |-> trig_req_i);

  p_throttle_blocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    throttle_i |-> !trig_acc_o);

  p_full_blocks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occupancy_o == OCC_W'(DEPTH)) |-> !trig_acc_o);

  p_unit_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (occupancy_o == $past(occupancy_o)) ||
             (occupancy_o == $past(occupancy_o) + OCC_W'(1)) ||
             (occupancy_o + OCC_W'(1) == $past(occupancy_o)));

  p_acc_no_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_acc_o |=> occupancy_o >= $past(occupancy_o));

  p_reject_inc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_req_i && !trig_acc_o && reject_cnt_o != '1) |=>
      reject_cnt_o == $past(reject_cnt_o) + CNT_W'(1));

  p_reject_mono_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> reject_cnt_o >= $past(reject_cnt_o));

  p_notfull_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !not_full_o |-> !trig_acc_o);
endmodule

bind occ_gate occ_gate_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .OCC_W(OCC_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .trig_req_i  (trig_req_i),
  .throttle_i  (throttle_i),
  .trig_acc_o  (trig_acc_o),
  .not_full_o  (not_full_o),
  .occupancy_o (occupancy_o),
  .reject_cnt_o(reject_cnt_o)
);

// File: tb/test_occ_gate.sv
module test_occ_gate;
  localparam int DEPTH = 15;
  localparam int WORDS = 36;
  localparam int CNT_W = 16;
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req = 1'b0;
  logic             thr = 1'b0;
  logic             acc, nf;
  logic [OCC_W-1:0] occ;
  logic [CNT_W-1:0] cnt;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int m_occ = 0, m_tmr = 0, m_cnt = 0;

  always #5 clk = ~clk;

  occ_gate #(.DEPTH(DEPTH), .WORDS(WORDS), .CNT_W(CNT_W)) i_occ_gate (
    .clk_i(clk), .rst_ni(rst_ni), .trig_req_i(req), .throttle_i(thr),
    .trig_acc_o(acc), .not_full_o(nf), .occupancy_o(occ), .reject_cnt_o(cnt)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_acc(bit r, bit t, int o);
    return r && !t && (o < DEPTH);
  endfunction

  // drive at negedge, compare before the next posedge, then advance the model
  task automatic step(bit r, bit t);
    bit a, d;
    @(negedge clk);
    req = r; thr = t;
    #1;
    a = exp_acc(r, t, m_occ);
    check(t ? "R3 throttle" : (m_occ == DEPTH ? "R4 full" : "R2 accept"), int'(acc), int'(a));
    check("R5 occupancy", int'(occ), m_occ);
    check("R9 not_full", int'(nf), int'(m_occ < DEPTH));
    check("R8 reject count", int'(cnt), m_cnt);
    d = (m_occ > 0) && (m_tmr == WORDS - 1);
    m_tmr = (m_occ == 0 || d) ? 0 : m_tmr + 1;
    m_occ = m_occ + int'(a) - int'(d);
    if (r && !a && m_cnt < CMAX) m_cnt++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; req = 1'b1; thr = 1'b0;
    #1;
    check("R1 acc in reset", int'(acc), 0);
    check("R1 occ in reset", int'(occ), 0);
    check("R1 cnt in reset", int'(cnt), 0);
    check("R1 not_full in reset", int'(nf), 1);
    m_occ = 0; m_tmr = 0; m_cnt = 0;
    @(negedge clk);
    req = 1'b0;
    rst_ni = 1'b1;
  endtask

  initial begin
    int hold, last_drop, prev;
    void'($urandom(32'h5eed_0042));
    do_reset();

    // R5: lone event held for WORDS cycles
    step(1, 0);
    hold = 0;
    for (int i = 0; i < 3 * WORDS; i++) begin
      step(0, 0);
      if (occ == 1) hold++;
    end
    check("R5 lone event hold cycles", hold, WORDS);

    // R4: burst of DEPTH+5 consecutive requests
    hold = 0;
    for (int i = 0; i < DEPTH + 5; i++) begin
      step(1, 0);
      if (acc) hold++;
    end
    check("R4 burst accepts", hold, DEPTH);

    // R6: drains spaced WORDS apart
    prev = int'(occ); last_drop = -1;
    for (int i = 0; i < 4 * WORDS; i++) begin
      step(0, 0);
      if (int'(occ) < prev) begin
        if (last_drop >= 0) check("R6 drain spacing", i - last_drop, WORDS);
        last_drop = i;
      end
      prev = int'(occ);
    end
    for (int i = 0; i < DEPTH * WORDS; i++) step(0, 0);
    check("R6 drained empty", int'(occ), 0);

    // R7: accept on the completion cycle of a lone event
    step(1, 0);
    for (int i = 0; i < WORDS - 1; i++) step(0, 0);
    step(1, 0);
    step(0, 0);
    check("R7 accept meets completion", int'(occ), 1);

    // R3: throttle with free space
    for (int i = 0; i < 5; i++) step(1, 1);

    // random mix
    for (int i = 0; i < 20000; i++)
      step(($urandom % 4) != 0, ($urandom % 8) == 0);

    // R1: reset from a busy state
    for (int i = 0; i < 6; i++) step(1, 0);
    do_reset();
    step(0, 0);

    // R8: saturation of the reject counter
    for (int i = 0; i < CMAX + 8; i++) step(1, 1);
    check("R8 saturated count", int'(cnt), CMAX);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule